// File: doc/BRIEF.md
# Unsigned Divider with Microcycle Cost Accounting

This block divides a 32-bit unsigned dividend by a 16-bit unsigned divisor and returns a 16-bit quotient and a 16-bit remainder. It works one shift-and-subtract step per clock, in the restoring style. It also adds up the number of internal microcycles that a microcoded implementation of the same divide would spend. Timing-faithful models use this count to charge each divide its data-dependent cost.

A caller pulses the start input with the operands applied. Two cases end at once with a fixed cost: a zero divisor, and a quotient that cannot fit in 16 bits. Every other divide enters the loop with an entry cost. Each of the first fifteen loop steps then adds a cost that depends on the branch the step takes. A sixteenth step completes the quotient and adds no cost. A one-cycle done pulse marks the moment when the results, the flags and the count can be read. These values stay unchanged until the next accepted start.

Top module: `udiv_cost`

## Requirements
- R1: After reset, done_o, div_zero_o and overflow_o are 0, and quotient_o, remainder_o and cost_o are all 0.
- R2: A start with divisor_i equal to 0 raises done_o on the same clock edge that samples start_i. At that edge div_zero_o becomes 1, overflow_o becomes 0, cost_o becomes 4, and quotient_o and remainder_o become 0.
- R3: A start with a nonzero divisor where dividend_i[31:16] >= divisor_i raises done_o on the edge that samples start_i. At that edge overflow_o becomes 1, div_zero_o becomes 0, cost_o becomes 3, and quotient_o and remainder_o become 0.
- R4: Any other start raises done_o exactly 16 clock edges after the edge that samples start_i. At that point quotient_o equals dividend_i / divisor_i, remainder_o equals dividend_i % divisor_i (so it is below divisor_i), and both flags are 0.
- R5: For a divide that enters the loop, cost_o at done equals 3 plus one term for each of the first 15 steps. Let P be the 32-bit partial remainder at the start of a step and D be divisor_i placed in bits 31:16. The term is 2 when bit 31 of P is 1. It is 3 when bit 31 of P is 0 and P shifted left by one is >= D. It is 4 otherwise. The 16th step adds nothing, so the cost lies between 33 and 63.
- R6: done_o is high for a single cycle. quotient_o, remainder_o, the flags and cost_o keep their values from the done edge until the next accepted start.
- R7: A start_i pulse that arrives while a divide is still in progress is ignored. The running divide finishes on its own schedule with its own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start pulse; operands are sampled on the same edge |
| dividend_i | input | 32 | Unsigned dividend |
| divisor_i | input | 16 | Unsigned divisor |
| quotient_o | output | 16 | Quotient, valid from done |
| remainder_o | output | 16 | Remainder, valid from done |
| div_zero_o | output | 1 | Divisor was zero |
| overflow_o | output | 1 | Quotient would not fit in 16 bits |
| cost_o | output | 8 | Accumulated microcycle cost |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Zero-divisor and overflow results are due on the edge that samples start. Divides that enter the loop complete 16 edges later. The bench drives start on a falling edge and then counts falling edges until done appears, so the measured latency must be exactly 1 or 17 falling edges. It compares every result in that same half-cycle against a divide and a cost walk that it computes itself. It then checks that done has dropped one cycle later and that all outputs still hold their values a few cycles after that.

// File: rtl/udiv_cost_pkg.sv
package udiv_cost_pkg;
  localparam int unsigned DVS_W  = 16;
  localparam int unsigned DVD_W  = 2 * DVS_W;
  localparam int unsigned COST_W = 8;
  localparam int unsigned RST_STAGES = 2;

  // microcycle costs
  localparam int unsigned C_ZERO  = 4;
  localparam int unsigned C_OVF   = 3;
  localparam int unsigned C_ENTRY = 3;
  localparam int unsigned C_MSB   = 2;
  localparam int unsigned C_SUB   = 3;
  localparam int unsigned C_NOSUB = 4;

  typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } run_state_e;
  typedef enum logic [1:0] { BR_MSB = 2'd0, BR_SUB = 2'd1, BR_NOSUB = 2'd2 } branch_e;
endpackage

// File: rtl/udiv_rst_sync.sv
module udiv_rst_sync #(
  parameter int unsigned STAGES = udiv_cost_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[g] <= 1'b0;
          else         chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/udiv_classify.sv
module udiv_classify
  import udiv_cost_pkg::*;
#(
  parameter int unsigned W      = DVS_W,
  parameter int unsigned COST_W = udiv_cost_pkg::COST_W
) (
  input  logic [W-1:0]      dvd_hi_i,
  input  logic [W-1:0]      dvs_i,
  output logic              zero_o,
  output logic              ovf_o,
  output logic              exc_o,
  output logic [COST_W-1:0] exc_cost_o
);
  always_comb begin
    zero_o     = (dvs_i == '0);
    ovf_o      = !zero_o && (dvd_hi_i >= dvs_i);
    exc_o      = zero_o || ovf_o;
    exc_cost_o = zero_o ? COST_W'(C_ZERO) : COST_W'(C_OVF);
  end
endmodule

// File: rtl/udiv_step.sv
module udiv_step
  import udiv_cost_pkg::*;
#(
  parameter int unsigned W = DVS_W
) (
  input  logic [2*W-1:0] rem_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] rem_o,
  output branch_e        branch_o
);
  logic [2*W-1:0] shifted;
  logic [W-1:0]   upper;

  always_comb begin
    shifted = {rem_i[2*W-2:0], 1'b0};
    upper   = shifted[2*W-1:W];
    rem_o   = shifted;
    if (rem_i[2*W-1]) begin
      // carry out of the shift: subtraction always fits
      rem_o[2*W-1:W] = upper - dvs_i;
      rem_o[0]       = 1'b1;
      branch_o       = BR_MSB;
    end else if (upper >= dvs_i) begin
      rem_o[2*W-1:W] = upper - dvs_i;
      rem_o[0]       = 1'b1;
      branch_o       = BR_SUB;
    end else begin
      branch_o       = BR_NOSUB;
    end
  end
endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
  import udiv_cost_pkg::*;
#(
  parameter int unsigned W = DVS_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic exc_i,
  output logic busy_o,
  output logic load_o,
  output logic exc_fin_o,
  output logic step_en_o,
  output logic cost_en_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  run_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             accept, last, cnt_en;

  always_comb begin
    accept    = start_i && (state_q == ST_IDLE);
    load_o    = accept && !exc_i;
    exc_fin_o = accept && exc_i;
    step_en_o = (state_q == ST_RUN);
    last      = (cnt_q == LAST);
    cost_en_o = step_en_o && !last;
    state_d   = state_q;
    cnt_d     = cnt_q;
    cnt_en    = load_o || step_en_o;
    if (load_o) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (step_en_o) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (last) state_d = ST_IDLE;
    end
    done_d = exc_fin_o || (step_en_o && last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/udiv_cost.sv
module udiv_cost
  import udiv_cost_pkg::*;
#(
  parameter int unsigned W      = DVS_W,
  parameter int unsigned COST_W = udiv_cost_pkg::COST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2*W-1:0]    dividend_i,
  input  logic [W-1:0]      divisor_i,
  output logic [W-1:0]      quotient_o,
  output logic [W-1:0]      remainder_o,
  output logic              div_zero_o,
  output logic              overflow_o,
  output logic [COST_W-1:0] cost_o,
  output logic              done_o
);
  logic              rst_sync_n;
  logic              is_zero, is_ovf, is_exc;
  logic [COST_W-1:0] exc_cost;
  logic              busy, load, exc_fin, step_en, cost_en;
  logic [2*W-1:0]    rem_q, rem_d, rem_step;
  logic [W-1:0]      dvs_q, dvs_d;
  logic [COST_W-1:0] cost_q, cost_d, step_cost;
  logic              dz_q, dz_d, ov_q, ov_d;
  logic              dp_en;
  branch_e           branch;

  udiv_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  udiv_classify #(.W(W), .COST_W(COST_W)) u_cls (
    .dvd_hi_i(dividend_i[2*W-1:W]), .dvs_i(divisor_i),
    .zero_o(is_zero), .ovf_o(is_ovf), .exc_o(is_exc), .exc_cost_o(exc_cost)
  );

  udiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .exc_i(is_exc),
    .busy_o(busy), .load_o(load), .exc_fin_o(exc_fin),
    .step_en_o(step_en), .cost_en_o(cost_en), .done_o(done_o)
  );

  udiv_step #(.W(W)) u_step (
    .rem_i(rem_q), .dvs_i(dvs_q), .rem_o(rem_step), .branch_o(branch)
  );

  always_comb begin
    unique case (branch)
      BR_MSB:  step_cost = COST_W'(C_MSB);
      BR_SUB:  step_cost = COST_W'(C_SUB);
      default: step_cost = COST_W'(C_NOSUB);
    endcase
  end

  // next-state of the datapath
  always_comb begin
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    cost_d = cost_q;
    dz_d   = dz_q;
    ov_d   = ov_q;
    dp_en  = exc_fin || load || step_en;
    if (exc_fin) begin
      rem_d  = '0;
      dvs_d  = divisor_i;
      cost_d = exc_cost;
      dz_d   = is_zero;
      ov_d   = is_ovf;
    end else if (load) begin
      rem_d  = dividend_i;
      dvs_d  = divisor_i;
      cost_d = COST_W'(C_ENTRY);
      dz_d   = 1'b0;
      ov_d   = 1'b0;
    end else if (step_en) begin
      rem_d = rem_step;
      if (cost_en) cost_d = cost_q + step_cost;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      cost_q <= '0;
      dz_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else if (dp_en) begin
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      cost_q <= cost_d;
      dz_q   <= dz_d;
      ov_q   <= ov_d;
    end
  end

  assign quotient_o  = rem_q[W-1:0];
  assign remainder_o = rem_q[2*W-1:W];
  assign div_zero_o  = dz_q;
  assign overflow_o  = ov_q;
  assign cost_o      = cost_q;
endmodule

// File: rtl/udiv_cost_chk.sv
module udiv_cost_chk
  import udiv_cost_pkg::*;
#(
  parameter int unsigned W      = DVS_W,
  parameter int unsigned COST_W = udiv_cost_pkg::COST_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy,
  input logic [W-1:0]      dvs_held,
  input logic [W-1:0]      quotient_o,
  input logic [W-1:0]      remainder_o,
  input logic              div_zero_o,
  input logic              overflow_o,
  input logic [COST_W-1:0] cost_o,
  input logic              done_o
);
  localparam int unsigned CMIN = C_ENTRY + (W - 1) * C_MSB;
  localparam int unsigned CMAX = C_ENTRY + (W - 1) * C_NOSUB;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o) && $stable(cost_o))); // R6
  AST_ZERO_COST: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && div_zero_o) |-> (cost_o == COST_W'(C_ZERO) && quotient_o == '0 && !overflow_o)); // R2
  AST_OVF_COST: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && overflow_o) |-> (cost_o == COST_W'(C_OVF) && remainder_o == '0)); // R3
  AST_COST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_zero_o && !overflow_o) |-> (cost_o >= COST_W'(CMIN) && cost_o <= COST_W'(CMAX))); // R5
  AST_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_zero_o && !overflow_o) |-> (remainder_o < dvs_held)); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> !(div_zero_o || overflow_o)); // R7
endmodule

bind udiv_cost udiv_cost_chk #(.W(W), .COST_W(COST_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .busy(busy), .dvs_held(dvs_q),
  .quotient_o(quotient_o), .remainder_o(remainder_o), .div_zero_o(div_zero_o),
  .overflow_o(overflow_o), .cost_o(cost_o), .done_o(done_o)
);

// File: tb/udiv_cost_tb_top.sv
module udiv_cost_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] dividend_i;
  logic [15:0] divisor_i;
  logic [15:0] quotient_o, remainder_o;
  logic        div_zero_o, overflow_o, done_o;
  logic [7:0]  cost_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk; // 50 MHz

  udiv_cost dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dividend_i(dividend_i),
    .divisor_i(divisor_i), .quotient_o(quotient_o), .remainder_o(remainder_o),
    .div_zero_o(div_zero_o), .overflow_o(overflow_o), .cost_o(cost_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_cost(input logic [31:0] d, input logic [15:0] v);
    logic [32:0] p;
    logic [32:0] dv;
    int c;
    c  = 3;
    p  = {1'b0, d};
    dv = {1'b0, v, 16'h0};
    for (int i = 0; i < 15; i++) begin
      if (p[31]) begin
        p = {p[31:0], 1'b0} - dv;
        c += 2;
      end else begin
        p = {1'b0, p[30:0], 1'b0};
        if (p >= dv) begin p = p - dv; c += 3; end
        else c += 4;
      end
    end
    return c;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_o == 0 && div_zero_o == 0 && overflow_o == 0, "R1", "done/flags", {done_o, div_zero_o, overflow_o}, 0);
    chk(quotient_o == 0 && remainder_o == 0, "R1", "q/r", {quotient_o, remainder_o}, 0);
    chk(cost_o == 0, "R1", "cost", cost_o, 0);
  endtask

  // runs one divide; if interrupt_at > 0 a start with a zero divisor is pulsed at that cycle
  task automatic t_divide(input logic [31:0] d, input logic [15:0] v, input int interrupt_at);
    bit dz, ov;
    int lat, elat, ecost;
    logic [15:0] eq, er, hq;
    logic [7:0]  hc;
    string req;
    dz    = (v == 0);
    ov    = !dz && (d[31:16] >= v);
    elat  = (dz || ov) ? 1 : 17;
    eq    = (dz || ov) ? 16'h0 : 16'(d / {16'h0, v});
    er    = (dz || ov) ? 16'h0 : 16'(d % {16'h0, v});
    ecost = dz ? 4 : (ov ? 3 : model_cost(d, v));
    req   = dz ? "R2" : (ov ? "R3" : "R4");
    @(negedge clk);
    start_i = 1'b1; dividend_i = d; divisor_i = v;
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      start_i = (interrupt_at > 0 && k == interrupt_at);
      if (start_i) divisor_i = 16'h0;
      if (done_o) begin lat = k; break; end
    end
    start_i = 1'b0;
    chk(lat == elat, req, "latency", lat, elat);
    chk(quotient_o == eq, req, "quotient", quotient_o, eq);
    chk(remainder_o == er, req, "remainder", remainder_o, er);
    chk(div_zero_o == dz && overflow_o == ov, req, "flags", {div_zero_o, overflow_o}, {dz, ov});
    chk(cost_o == 8'(ecost), (dz || ov) ? req : "R5", "cost", cost_o, ecost);
    if (interrupt_at > 0) chk(lat == 17 && !div_zero_o, "R7", "start while busy", lat, 17);
    hq = quotient_o; hc = cost_o;
    @(negedge clk);
    chk(done_o == 0, "R6", "done pulse width", done_o, 0);
    repeat (3) @(negedge clk);
    chk(quotient_o == hq && cost_o == hc, "R6", "hold", {quotient_o, cost_o}, {hq, hc});
  endtask

  initial begin
    t_reset();
    t_divide(32'd100, 16'd7, 0);
    t_divide(32'hFFFE_FFFF, 16'hFFFF, 0);  // MSB branch heavy
    t_divide(32'd0, 16'd5, 0);             // all no-subtract: cost 63
    t_divide(32'h0000_FFFF, 16'd1, 0);
    t_divide(32'd1234, 16'd0, 0);          // divide by zero
    t_divide(32'h0005_0000, 16'd5, 0);     // overflow at equality
    t_divide(32'hFFFF_0000, 16'h1234, 0);  // overflow
    t_divide(32'h0004_FFFF, 16'd5, 0);     // just below overflow
    t_divide(32'd1000, 16'd3, 5);          // start while busy
    begin
      logic [31:0] s;
      s = 32'h1234_5678;
      for (int i = 0; i < 8; i++) begin
        logic [15:0] v;
        logic [31:0] d;
        s = s * 32'd1664525 + 32'd1013904223;
        v = s[31:16] | 16'h1;
        s = s * 32'd1664525 + 32'd1013904223;
        d = {s[31:16] % v, s[15:0]};
        t_divide(d, v, 0);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule